// File: doc/BRIEF.md
# Increment-Only Word Write Guard

This block sits in front of a small non-volatile array and rules on each pending word write before it reaches storage. The lowest part of the address space is a window of 16-bit counters that may only move upward. A word write that lands in that window is allowed only when the new value is strictly greater, as an unsigned number, than the word already held there. Writes outside the window are not judged on their value. They are handed on to the separate block-protect check.

The surrounding write engine splits any multi-byte write into words and presents them one at a time. For each word it presents the byte address, the new word, the word currently stored at that location and a one-cycle request strobe. One clock edge later the guard shows its verdict on registered flags: allow, reject, and a flag that says whether the word fell inside the counter window. The storage array and the serial command interface are outside this block.

Top module: `incr_word_guard`

## Requirements
- R1: While reset is high, and in the first cycle after it, `allow_o`, `reject_o` and `in_window_o` are all 0.
- R2: The verdict flags are registered. A request sampled at a clock edge is reported on the outputs from that edge until the next one. After an edge where `req_i` was 0, `allow_o` and `reject_o` are both 0.
- R3: A request whose address bits [9:0] lie in 0x000..0x01F is in the counter window, reported as `in_window_o` = 1. Such a request is allowed (`allow_o` = 1) when `new_word_i` > `stored_word_i`.
- R4: In the window, a new word equal to the stored word is rejected (`reject_o` = 1, `allow_o` = 0).
- R5: The comparison is unsigned 16-bit. In the window, 0x8000 over a stored 0x7FFF is allowed, and 0x7FFF over a stored 0x8000 is rejected.
- R6: A request whose address bits [9:0] are 0x020 or above is outside the window (`in_window_o` = 0). It is allowed whatever the two data words are.
- R7: Address bits [15:10] play no part in the decode. 0xFC10 is inside the window and 0x0420 is outside it.
- R8: After every request exactly one of `allow_o` and `reject_o` is 1.
- R9: The reject flag is high only in the cycle after a rejected request. Two rejected requests in a row give two high cycles, and an idle cycle that follows brings the flag back to 0.
- R10: The odd byte address of a word is judged the same way as the even one. 0x01F is the last address in the window and 0x020 is the first address outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | One-cycle strobe: a word write is pending |
| addr_i | input | 16 | Byte address of the write |
| new_word_i | input | 16 | Word the write wants to store |
| stored_word_i | input | 16 | Word currently held at that location |
| allow_o | output | 1 | Write may proceed (registered) |
| reject_o | output | 1 | Write is refused, storage stays unchanged (registered) |
| in_window_o | output | 1 | Request fell in the counter window (registered) |

## Verification
The bench aims at the window edges: 0x01F against 0x020, and addresses whose upper six bits are set. A decoder that used too many address bits or misplaced the limit would let a counter be written downward, or would refuse ordinary writes. The bench also writes equal values and values that differ in the top bit. A `>=` compare would accept equal values, and a signed compare would get the 0x8000/0x7FFF pair backwards. Back-to-back and idle cycles catch a reject flag that sticks high or does not clear.

// File: rtl/incr_guard_pkg.sv
package incr_guard_pkg;
  localparam int ADDR_W   = 16;
  localparam int WORD_W   = 16;
  localparam int DECODE_W = 10;
  localparam int WIN_LAST = 32'h01F;

  typedef struct packed {
    logic allow;
    logic reject;
    logic in_window;
  } verdict_t;
endpackage

// File: rtl/guard_window_decode.sv
module guard_window_decode #(
  parameter int ADDR_W   = 16,
  parameter int DECODE_W = 10,
  parameter int WIN_LAST = 32'h01F
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_window_o
);
  localparam logic [DECODE_W-1:0] LAST = DECODE_W'(WIN_LAST);

  logic [DECODE_W-1:0] decoded;

  // Only the low DECODE_W address bits take part in the decode.
  assign decoded     = addr_i[DECODE_W-1:0];
  assign in_window_o = (decoded <= LAST);
endmodule

// File: rtl/guard_word_compare.sv
module guard_word_compare #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] new_word_i,
  input  logic [WORD_W-1:0] stored_word_i,
  output logic              greater_o
);
  // Unsigned and strict: a value equal to the stored one does not count as larger.
  assign greater_o = (new_word_i > stored_word_i);
endmodule

// File: rtl/guard_verdict.sv
module guard_verdict
  import incr_guard_pkg::*;
(
  input  logic     req_i,
  input  logic     in_window_i,
  input  logic     greater_i,
  output verdict_t verdict_o
);
  always_comb begin
    verdict_o = '0;
    if (req_i) begin
      verdict_o.in_window = in_window_i;
      verdict_o.allow     = !in_window_i || greater_i;
      verdict_o.reject    = in_window_i && !greater_i;
    end
  end
endmodule

// File: rtl/incr_word_guard.sv
module incr_word_guard
  import incr_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] new_word_i,
  input  logic [WORD_W-1:0] stored_word_i,
  output logic              allow_o,
  output logic              reject_o,
  output logic              in_window_o
);
  logic     in_window;
  logic     greater;
  verdict_t verdict_d;
  verdict_t verdict_q;

  guard_window_decode #(
    .ADDR_W  (ADDR_W),
    .DECODE_W(DECODE_W),
    .WIN_LAST(WIN_LAST)
  ) u_decode (
    .addr_i     (addr_i),
    .in_window_o(in_window)
  );

  guard_word_compare #(
    .WORD_W(WORD_W)
  ) u_compare (
    .new_word_i   (new_word_i),
    .stored_word_i(stored_word_i),
    .greater_o    (greater)
  );

  guard_verdict u_verdict (
    .req_i      (req_i),
    .in_window_i(in_window),
    .greater_i  (greater),
    .verdict_o  (verdict_d)
  );

  always_ff @(posedge clk) begin
    if (rst) verdict_q <= '0;
    else     verdict_q <= verdict_d;
  end

  assign allow_o     = verdict_q.allow;
  assign reject_o    = verdict_q.reject;
  assign in_window_o = verdict_q.in_window;

  // R8: the two verdict flags are never high together
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(allow_o && reject_o));

  // R8: every request gets exactly one verdict on the next cycle
  a_r8_one_verdict: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (allow_o ^ reject_o));

  // R2: an idle cycle produces no verdict
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!allow_o && !reject_o));

  // R3: a larger value inside the window is allowed
  a_r3_increase_ok: assert property (@(posedge clk) disable iff (rst)
    (req_i && addr_i[DECODE_W-1:0] <= DECODE_W'(WIN_LAST) && new_word_i > stored_word_i)
      |=> allow_o);

  // R4: an equal value inside the window is refused
  a_r4_equal_refused: assert property (@(posedge clk) disable iff (rst)
    (req_i && addr_i[DECODE_W-1:0] <= DECODE_W'(WIN_LAST) && new_word_i == stored_word_i)
      |=> reject_o);

  // R6: outside the window the value is not judged
  a_r6_outside_pass: assert property (@(posedge clk) disable iff (rst)
    (req_i && addr_i[DECODE_W-1:0] > DECODE_W'(WIN_LAST)) |=> (allow_o && !in_window_o));
endmodule

// File: tb/tb_incr_word_guard.sv
`timescale 1ns/1ps
module tb_incr_word_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [15:0] new_word_i = '0;
  logic [15:0] stored_word_i = '0;
  logic        allow_o, reject_o, in_window_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  allow;
    logic  reject;
    logic  win;
    string tag;
  } exp_t;

  exp_t sb[$];
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  incr_word_guard dut (
    .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i),
    .new_word_i(new_word_i), .stored_word_i(stored_word_i),
    .allow_o(allow_o), .reject_o(reject_o), .in_window_o(in_window_o)
  );

  // Drive one cycle of stimulus and queue the verdict the requirements predict.
  task automatic drive(input logic rq, input logic [15:0] a, input logic [15:0] nw,
                       input logic [15:0] sw, input string tag);
    exp_t e;
    logic win;
    @(negedge clk);
    req_i = rq; addr_i = a; new_word_i = nw; stored_word_i = sw;
    win = (a[9:0] <= 10'h01F);
    e.tag    = tag;
    e.win    = rq && win;
    e.allow  = rq && (!win || (nw > sw));
    e.reject = rq && win && !(nw > sw);
    sb.push_back(e);
  endtask

  // Monitor: the result of the stimulus queued at a negedge shows after the next posedge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (allow_o !== e.allow || reject_o !== e.reject || in_window_o !== e.win) begin
          errors++;
          $display("FAIL %s: got allow=%b reject=%b win=%b, expected allow=%b reject=%b win=%b",
                   e.tag, allow_o, reject_o, in_window_o, e.allow, e.reject, e.win);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs cleared while reset is held, even with a request pending
    req_i = 1'b1; addr_i = 16'h0004; new_word_i = 16'h0009; stored_word_i = 16'h0001;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({allow_o, reject_o, in_window_o} !== 3'b000) begin
      errors++;
      $display("FAIL R1: got %b%b%b, expected 000", allow_o, reject_o, in_window_o);
    end
    @(negedge clk);
    req_i = 1'b0;
    rst = 1'b0;
    drive(1'b0, 16'h0000, 16'h0000, 16'h0000, "R1 first cycle after reset");

    drive(1'b0, 16'h0002, 16'hFFFF, 16'h0000, "R2 idle with window data");
    drive(1'b1, 16'h0004, 16'h0005, 16'h0004, "R3 increase in window");
    drive(1'b1, 16'h0010, 16'h1234, 16'h0FFF, "R3 larger word allowed");
    drive(1'b1, 16'h0006, 16'h0003, 16'h0004, "R5 decrease rejected");
    drive(1'b1, 16'h0008, 16'h8000, 16'h7FFF, "R5 unsigned 8000 over 7FFF");
    drive(1'b1, 16'h000A, 16'h7FFF, 16'h8000, "R5 unsigned 7FFF over 8000");
    drive(1'b1, 16'h000C, 16'h00AA, 16'h00AA, "R4 equal rejected");
    drive(1'b1, 16'h0000, 16'hFFFF, 16'hFFFF, "R4 equal at max");
    drive(1'b1, 16'h001F, 16'h0002, 16'h0001, "R10 odd last address allowed");
    drive(1'b1, 16'h001F, 16'h0001, 16'h0002, "R10 odd last address rejected");
    drive(1'b1, 16'h001E, 16'h0001, 16'h0001, "R10 even last word equal");
    drive(1'b1, 16'h0020, 16'h0001, 16'h0002, "R6 first outside address");
    drive(1'b1, 16'h03FF, 16'h0000, 16'hFFFF, "R6 top of array");
    drive(1'b1, 16'h0021, 16'h0005, 16'h0005, "R6 equal outside passes");
    drive(1'b1, 16'hFC10, 16'h0001, 16'h0002, "R7 upper bits ignored in window");
    drive(1'b1, 16'h0420, 16'h0001, 16'h0002, "R7 upper bits ignored outside");
    drive(1'b1, 16'hFFFF, 16'h0000, 16'h0001, "R7 all ones address outside");
    drive(1'b1, 16'h0002, 16'h0001, 16'h0009, "R9 first reject");
    drive(1'b1, 16'h0004, 16'h0009, 16'h0009, "R9 second reject");
    drive(1'b0, 16'h0004, 16'h0009, 16'h0009, "R9 reject clears on idle");
    drive(1'b1, 16'h0012, 16'h0001, 16'h0000, "R8 allow after reject");
    drive(1'b1, 16'h0014, 16'h0000, 16'h0000, "R8 reject after allow");
    drive(1'b0, 16'h0000, 16'h0000, 16'h0000, "R2 final idle");
    @(negedge clk);
    req_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule